// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block sits between the mailbox register file of a CAN controller and its frame serializer. It holds one transmit-request bit per mailbox. Each cycle that the serializer is free, it scans every mailbox that is enabled, set for transmit, and has a request pending. It picks a single winner by the priority field in that mailbox's control word. If priorities are equal, the higher mailbox number wins.

The winner's index, data length code and remote-frame flag are given to the serializer with a one-cycle start pulse. The arbiter then waits for the serializer to report either completion or lost bus arbitration. A completed send clears the request and sets the mailbox's transmit-acknowledge bit, which can raise the global mailbox interrupt. A lost arbitration leaves the request pending for the next round. Software can withdraw a request that has not started. That records an abort acknowledge and no transmit acknowledge.

The control logic is a three-state machine:
- ARB_IDLE: selection is open.
- ARB_LAUNCH: the start pulse is out.
- ARB_INFLIGHT: waiting on the serializer.

Its transitions are:
- IDLE→LAUNCH when any mailbox is eligible; the winner is latched.
- LAUNCH→INFLIGHT unconditionally.
- INFLIGHT→IDLE on done or on lost.
- The machine otherwise holds its state.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset, no request, transmit-acknowledge or abort-acknowledge bit is set, `tx_start` is low and `mbx_irq` is low.
- R2: A one in bit i of `req_set_w1` sets request bit i in the cycle after; zero bits leave requests unchanged.
- R3: A mailbox is eligible only when its `mbx_en` bit is 1 and its `mbx_dir` bit is 0. Pending requests of other mailboxes stay pending and never start.
- R4: Mailbox i has a 16-bit control word at `mbx_ctrl[16*i+15:16*i]` whose bits 13:8 are its priority. Among eligible mailboxes the numerically highest priority is sent first.
- R5: When several eligible mailboxes share the highest priority, the highest-numbered one is sent first.
- R6: `tx_start` is high for exactly one cycle, the cycle after selection. With it, `tx_mbx` gives the winner, `tx_dlc` gives control bits 3:0 and `tx_rtr` gives control bit 4.
- R7: `ser_done` while in flight clears the mailbox's request and sets its `tx_ack` bit in the cycle after. A one in `ack_clr_w1` clears that `tx_ack` bit.
- R8: `mbx_irq` is high exactly when some `tx_ack` bit is set whose `irq_mask` bit is 1.
- R9: A one in `req_reset_w1` for a pending mailbox that is not being sent does the following. It clears the request, sets its `abort_ack` bit and leaves `tx_ack` unchanged. A one in `abort_clr_w1` clears `abort_ack`.
- R10: While a send is in flight, the selected mailbox is locked. A request reset on it is ignored, and a higher-priority request does not change the selection until done or lost.
- R11: `ser_lost` (without `ser_done`) while in flight keeps the request pending and returns to selection, so the mailbox competes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbx_en | input | 32 | Per-mailbox enable |
| mbx_dir | input | 32 | Per-mailbox direction, 1 = receive |
| mbx_ctrl | input | 512 | Control words, 16 bits per mailbox |
| irq_mask | input | 32 | Per-mailbox interrupt mask |
| req_set_w1 | input | 32 | Write-one-to-set transmit request |
| req_reset_w1 | input | 32 | Write-one-to-withdraw transmit request |
| ack_clr_w1 | input | 32 | Write-one-to-clear transmit acknowledge |
| abort_clr_w1 | input | 32 | Write-one-to-clear abort acknowledge |
| ser_done | input | 1 | Serializer finished the frame |
| ser_lost | input | 1 | Serializer lost bus arbitration |
| tx_start | output | 1 | One-cycle start to serializer |
| tx_mbx | output | 5 | Selected mailbox index |
| tx_dlc | output | 4 | Data length code of selected mailbox |
| tx_rtr | output | 1 | Remote frame flag of selected mailbox |
| req_pending | output | 32 | Transmit request bits |
| tx_ack | output | 32 | Transmit acknowledge bits |
| abort_ack | output | 32 | Abort acknowledge bits |
| mbx_irq | output | 1 | Global mailbox interrupt flag |

## Verification
The in-RTL properties check the cycle-level rules on every cycle:
- the start pulse is single-cycle and is only given for a pending mailbox;
- the selection stays frozen while in flight;
- done yields an acknowledge and a cleared request;
- lost keeps the request;
- a locked mailbox survives a request reset.

Which mailbox wins, under which priority and tie patterns, and whether ineligible mailboxes are truly skipped, only the bench shows. It drains many priority, enable and direction patterns and compares each winner against an arithmetic model. The interrupt masking and the abort bookkeeping are also bench-only.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE     = 2'd0,
        ARB_LAUNCH   = 2'd1,
        ARB_INFLIGHT = 2'd2
    } arb_state_e;

    localparam int CTRL_W   = 16;
    localparam int PRIO_LSB = 8;
    localparam int PRIO_W   = 6;
    localparam int RTR_BIT  = 4;
    localparam int DLC_W    = 4;
endpackage

// File: rtl/tx_prio_select.sv
module tx_prio_select #(
    parameter int N  = 32,
    parameter int PW = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]    eligible,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   win_idx
);
    logic [PW-1:0] best;

    // Ascending scan with >= so a later (higher-numbered) mailbox wins ties.
    always_comb begin
        found   = 1'b0;
        best    = '0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && (!found || prio_flat[i*PW +: PW] >= best)) begin
                found   = 1'b1;
                best    = prio_flat[i*PW +: PW];
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tx_req_bank.sv
module tx_req_bank #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_set,
    input  logic [N-1:0]  req_reset,
    input  logic [N-1:0]  ack_clr,
    input  logic [N-1:0]  abort_clr,
    input  logic          lock_valid,
    input  logic [IW-1:0] lock_idx,
    input  logic          done_pulse,
    output logic [N-1:0]  pend_q,
    output logic [N-1:0]  ack_q,
    output logic [N-1:0]  aa_q
);
    logic [N-1:0] lock_vec;
    logic [N-1:0] done_vec;
    logic [N-1:0] withdraw;

    always_comb begin
        lock_vec = lock_valid ? (N'(1) << lock_idx) : '0;
        done_vec = done_pulse ? lock_vec : '0;
        withdraw = req_reset & ~lock_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ack_q  <= '0;
            aa_q   <= '0;
        end else begin
            pend_q <= (pend_q | req_set) & ~withdraw & ~done_vec;
            ack_q  <= (ack_q & ~ack_clr) | done_vec;
            aa_q   <= (aa_q & ~abort_clr) | (withdraw & pend_q);
        end
    end

    // R10: the locked mailbox keeps its request while the send is open
    p_locked_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid && !done_pulse) |=> pend_q[$past(lock_idx)]);
endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
    import can_txarb_pkg::*;
#(
    parameter int NUM_MBX = 32,
    localparam int IW     = $clog2(NUM_MBX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MBX-1:0]        mbx_en,
    input  logic [NUM_MBX-1:0]        mbx_dir,
    input  logic [NUM_MBX*CTRL_W-1:0] mbx_ctrl,
    input  logic [NUM_MBX-1:0]        irq_mask,
    input  logic [NUM_MBX-1:0]        req_set_w1,
    input  logic [NUM_MBX-1:0]        req_reset_w1,
    input  logic [NUM_MBX-1:0]        ack_clr_w1,
    input  logic [NUM_MBX-1:0]        abort_clr_w1,
    input  logic                      ser_done,
    input  logic                      ser_lost,
    output logic                      tx_start,
    output logic [IW-1:0]             tx_mbx,
    output logic [DLC_W-1:0]          tx_dlc,
    output logic                      tx_rtr,
    output logic [NUM_MBX-1:0]        req_pending,
    output logic [NUM_MBX-1:0]        tx_ack,
    output logic [NUM_MBX-1:0]        abort_ack,
    output logic                      mbx_irq
);
    arb_state_e state_q, state_d;
    logic [IW-1:0] cur_idx_q;
    logic [IW-1:0] win_idx;
    logic          win_found;
    logic          lock_valid;
    logic          done_pulse;
    logic [NUM_MBX-1:0] eligible;
    logic [NUM_MBX*PRIO_W-1:0] prio_flat;

    genvar g;
    generate
        for (g = 0; g < NUM_MBX; g++) begin : g_prio
            assign prio_flat[g*PRIO_W +: PRIO_W] = mbx_ctrl[g*CTRL_W + PRIO_LSB +: PRIO_W];
        end
    endgenerate

    assign eligible = mbx_en & ~mbx_dir & req_pending;

    tx_prio_select #(.N(NUM_MBX), .PW(PRIO_W), .IW(IW)) u_select (
        .eligible  (eligible),
        .prio_flat (prio_flat),
        .found     (win_found),
        .win_idx   (win_idx)
    );

    tx_req_bank #(.N(NUM_MBX), .IW(IW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set    (req_set_w1),
        .req_reset  (req_reset_w1),
        .ack_clr    (ack_clr_w1),
        .abort_clr  (abort_clr_w1),
        .lock_valid (lock_valid),
        .lock_idx   (cur_idx_q),
        .done_pulse (done_pulse),
        .pend_q     (req_pending),
        .ack_q      (tx_ack),
        .aa_q       (abort_ack)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:     if (win_found) state_d = ARB_LAUNCH;
            ARB_LAUNCH:   state_d = ARB_INFLIGHT;
            ARB_INFLIGHT: if (ser_done || ser_lost) state_d = ARB_IDLE;
            default:      state_d = ARB_IDLE;
        endcase
    end

    // State register and winner latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ARB_IDLE;
            cur_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && win_found) cur_idx_q <= win_idx;
        end
    end

    // Outputs
    always_comb begin
        tx_start   = (state_q == ARB_LAUNCH);
        lock_valid = (state_q != ARB_IDLE);
        done_pulse = (state_q == ARB_INFLIGHT) && ser_done;
        tx_mbx     = cur_idx_q;
        tx_dlc     = mbx_ctrl[int'(cur_idx_q)*CTRL_W +: DLC_W];
        tx_rtr     = mbx_ctrl[int'(cur_idx_q)*CTRL_W + RTR_BIT];
        mbx_irq    = |(tx_ack & irq_mask);
    end

    // R6: start lasts one cycle and names a pending mailbox
    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    p_start_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> req_pending[tx_mbx]);
    // R7: completion acknowledges and clears the request
    p_done_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (tx_ack[$past(cur_idx_q)] && !req_pending[$past(cur_idx_q)]));
    // R11: lost arbitration keeps the request and reopens selection
    p_lost_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_INFLIGHT && ser_lost && !ser_done) |=>
            (req_pending[$past(cur_idx_q)] && state_q == ARB_IDLE));
    // R10: selection frozen while a send is open
    p_idx_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ARB_IDLE) |=> $stable(cur_idx_q));
endmodule

// File: tb/tb_can_txmb_arbiter.sv
module tb_can_txmb_arbiter;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] mbx_en = '0, mbx_dir = '0, irq_mask = '0;
    logic [N*16-1:0] mbx_ctrl = '0;
    logic [N-1:0] req_set_w1 = '0, req_reset_w1 = '0, ack_clr_w1 = '0, abort_clr_w1 = '0;
    logic ser_done = 1'b0, ser_lost = 1'b0;
    logic tx_start, tx_rtr, mbx_irq;
    logic [4:0] tx_mbx;
    logic [3:0] tx_dlc;
    logic [N-1:0] req_pending, tx_ack, abort_ack;

    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    can_txmb_arbiter dut (
        .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en), .mbx_dir(mbx_dir),
        .mbx_ctrl(mbx_ctrl), .irq_mask(irq_mask), .req_set_w1(req_set_w1),
        .req_reset_w1(req_reset_w1), .ack_clr_w1(ack_clr_w1),
        .abort_clr_w1(abort_clr_w1), .ser_done(ser_done), .ser_lost(ser_lost),
        .tx_start(tx_start), .tx_mbx(tx_mbx), .tx_dlc(tx_dlc), .tx_rtr(tx_rtr),
        .req_pending(req_pending), .tx_ack(tx_ack), .abort_ack(abort_ack),
        .mbx_irq(mbx_irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int prio_of(input int t, input int i);
        if (t == 0) return 5;
        if (t == 1) return (i < 16) ? 63 : 20;
        return (i * (2 * t + 1) + t * 11) % 64;
    endfunction

    task automatic pulse(ref logic [N-1:0] sig, input logic [N-1:0] val);
        sig = val;
        @(negedge clk);
        sig = '0;
    endtask

    task automatic wait_start(output int idx, output bit seen);
        seen = 0;
        idx = -1;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            if (tx_start) begin
                seen = 1;
                idx = int'(tx_mbx);
            end
        end
    endtask

    task automatic finish_done();
        @(negedge clk);
        ser_done = 1'b1;
        @(negedge clk);
        ser_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int idx;
        bit seen;
        logic [N-1:0] model_pend, served, elig;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_pending == 0 && tx_ack == 0 && abort_ack == 0, "R1", req_pending | tx_ack | abort_ack, 0);
        chk(!tx_start && !mbx_irq, "R1", {tx_start, mbx_irq}, 0);

        // R2 set and zero-write
        pulse(req_set_w1, 32'h0000_A501);
        chk(req_pending == 32'h0000_A501, "R2", req_pending, 32'h0000_A501);
        pulse(req_set_w1, 32'h0);
        chk(req_pending == 32'h0000_A501, "R2", req_pending, 32'h0000_A501);
        pulse(req_reset_w1, '1);
        pulse(abort_clr_w1, '1);
        chk(req_pending == 0 && abort_ack == 0, "R9", req_pending | abort_ack, 0);

        for (int t = 0; t < 8; t++) begin
            logic [N-1:0] en_pat, dir_pat;
            for (int i = 0; i < N; i++) begin
                mbx_ctrl[16*i +: 16] = {2'b00, 6'(prio_of(t, i)), 3'b000, 1'((i + t) & 1), 4'((i + t) % 9)};
                en_pat[i]  = (t == 0) ? 1'b1 : ((i + t) % 5 != 0);
                dir_pat[i] = (t == 0) ? 1'b0 : (i % 7 == t % 7);
            end
            mbx_dir = dir_pat;
            pulse(req_set_w1, '1);
            chk(req_pending == '1, "R2", req_pending, 32'hFFFF_FFFF);
            mbx_en = en_pat;
            model_pend = '1;
            served = '0;
            forever begin
                int best, cnt_best, exp_idx;
                elig = model_pend & en_pat & ~dir_pat;
                if (elig == 0) break;
                best = -1; exp_idx = -1; cnt_best = 0;
                for (int i = 0; i < N; i++)
                    if (elig[i] && prio_of(t, i) >= best) begin
                        if (prio_of(t, i) == best) cnt_best++; else cnt_best = 1;
                        best = prio_of(t, i);
                        exp_idx = i;
                    end
                wait_start(idx, seen);
                if (cnt_best > 1) chk(seen && idx == exp_idx, "R5", idx, exp_idx);
                else              chk(seen && idx == exp_idx, "R4", idx, exp_idx);
                if (!seen) break;
                chk(tx_dlc == 4'((exp_idx + t) % 9) && tx_rtr == 1'((exp_idx + t) & 1), "R6",
                    {tx_rtr, tx_dlc}, {1'((exp_idx + t) & 1), 4'((exp_idx + t) % 9)});
                finish_done();
                model_pend[exp_idx] = 1'b0;
                served[exp_idx] = 1'b1;
                chk(tx_ack[exp_idx] && !req_pending[exp_idx], "R7", {tx_ack[exp_idx], req_pending[exp_idx]}, 2'b10);
            end
            // R3: ineligible requests stay pending and never start
            seen = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (tx_start) seen = 1;
            end
            chk(!seen && req_pending == model_pend, "R3", req_pending, model_pend);
            chk(tx_ack == served, "R7", tx_ack, served);
            // R8 interrupt masking
            irq_mask = ~served;
            #1 chk(mbx_irq == 1'b0, "R8", mbx_irq, 0);
            irq_mask = served & (~served + 1);
            #1 chk(mbx_irq == (served != 0), "R8", mbx_irq, served != 0);
            irq_mask = '0;
            // R9 withdraw the remaining requests
            pulse(req_reset_w1, '1);
            chk(req_pending == 0 && abort_ack == model_pend, "R9", abort_ack, model_pend);
            chk(tx_ack == served, "R9", tx_ack, served);
            pulse(ack_clr_w1, '1);
            pulse(abort_clr_w1, '1);
            chk(tx_ack == 0 && abort_ack == 0, "R7", tx_ack | abort_ack, 0);
            mbx_en = '0;
        end

        // R10 / R11 lock and lost arbitration
        mbx_dir = '0;
        mbx_ctrl = '0;
        mbx_ctrl[16*3 +: 16]  = {2'b00, 6'd10, 8'h02};
        mbx_ctrl[16*20 +: 16] = {2'b00, 6'd40, 8'h18};
        mbx_en = '1;
        pulse(req_set_w1, 32'h0000_0008);
        wait_start(idx, seen);
        chk(seen && idx == 3, "R10", idx, 3);
        @(negedge clk);
        req_set_w1 = 32'h0010_0000;
        req_reset_w1 = 32'h0000_0008;
        @(negedge clk);
        req_set_w1 = '0;
        req_reset_w1 = '0;
        chk(req_pending == 32'h0010_0008 && abort_ack == 0, "R10", req_pending, 32'h0010_0008);
        seen = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (tx_start || tx_mbx != 5'd3) seen = 1;
        end
        chk(!seen, "R10", tx_mbx, 3);
        ser_lost = 1'b1;
        @(negedge clk);
        ser_lost = 1'b0;
        chk(req_pending[3] && tx_ack == 0, "R11", req_pending, 32'h0010_0008);
        wait_start(idx, seen);
        chk(seen && idx == 20 && tx_rtr && tx_dlc == 4'h8, "R11", idx, 20);
        finish_done();
        wait_start(idx, seen);
        chk(seen && idx == 3, "R11", idx, 3);
        finish_done();
        chk(tx_ack == 32'h0010_0008 && req_pending == 0, "R7", tx_ack, 32'h0010_0008);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule